// File: doc/BRIEF.md
# Return-from-Trap Control Unit

This block makes the decision for a return-from-trap instruction. On a single-cycle strobe it looks at the supervisor bit, the trap-enable bit, the debug-mode flag and the debug field of the instruction. It then picks one of several outcomes, tested in a fixed order. The instruction may halt. It may raise an illegal-instruction request. It may fall through to the next sequential address. It may return to the saved address of normal operation, or to the saved address of debug operation.

Each return path restores the trap-enable and supervisor bits from its own saved source. The debug path also ends debug mode. All results are registered and appear in the cycle after the strobe, so the surrounding pipeline can apply the new PC, the status write and the debug-mode exit together.

Program counters are treated as word addresses. The two low bits of every PC input are forced to zero before use, and sequential steps add four modulo 2^32.

Top module: `rett_unit`

## Requirements
- R1: While reset is high and in the cycle after it, every outcome pulse (redirect_o, illegal_o, halt_o, stat_we_o, dbg_exit_o) is 0, and next_pc_o, stat_et_o and stat_sup_o are 0.
- R2: A strobe with sup_i=0 and trap_en_i=0 gives halt_o=1 and next_pc_o = (pc_i with its low two bits cleared) + 4. No status write takes place.
- R3: A strobe with sup_i=0 and trap_en_i=1 gives redirect_o=1 and next_pc_o = aligned pc_i + 4. There is no status write, no illegal request and no halt.
- R4: A strobe with sup_i=1 and trap_en_i=1 gives illegal_o=1 and next_pc_o = aligned pc_i + 4. No status write takes place.
- R5: A strobe with sup_i=1, trap_en_i=0, dbg_state_i=0 and dbg_field_i=0 gives the following: redirect_o=1, next_pc_o = aligned norm_save_pc_i, stat_we_o=1, stat_et_o=1, stat_sup_o=prev_sup_i, and dbg_exit_o=0.
- R6: A strobe with sup_i=1, trap_en_i=0, dbg_state_i=1 and dbg_field_i=1 gives the following: redirect_o=1, next_pc_o = aligned dbg_save_pc_i, stat_we_o=1, stat_et_o=dbg_save_et_i, stat_sup_o=dbg_save_sup_i, and dbg_exit_o=1.
- R7: A strobe with sup_i=1 and trap_en_i=0, where dbg_state_i differs from dbg_field_i, gives redirect_o=1 and next_pc_o = aligned pc_i + 4. Both stat_we_o and dbg_exit_o stay 0.
- R8: The user-mode check takes priority over everything else. With sup_i=0, no status write and no debug exit happen, whatever the debug flag, the debug field and the saved bits are.
- R9: Outcomes appear exactly one cycle after valid_i. In a cycle that follows a cycle without valid_i, all pulses are 0 and next_pc_o keeps its value.
- R10: Every strobe asserts exactly one of redirect_o, illegal_o and halt_o in the following cycle.
- R11: next_pc_o always has its two low bits at zero. The sequential step wraps modulo 2^32.
- R12: stat_et_o and stat_sup_o are 0 in any cycle where stat_we_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Single-cycle strobe for a return-from-trap instruction |
| pc_i | input | 32 | Address of the instruction |
| norm_save_pc_i | input | 32 | Saved return address for normal operation |
| dbg_save_pc_i | input | 32 | Saved return address for debug operation |
| sup_i | input | 1 | Current supervisor bit |
| trap_en_i | input | 1 | Current trap-enable bit |
| prev_sup_i | input | 1 | Previous supervisor bit, restored on a normal return |
| dbg_save_et_i | input | 1 | Saved trap-enable bit for a debug return |
| dbg_save_sup_i | input | 1 | Saved supervisor bit for a debug return |
| dbg_state_i | input | 1 | Processor is in debug mode |
| dbg_field_i | input | 1 | Debug field of the instruction |
| next_pc_o | output | 32 | Next program counter, held between strobes |
| redirect_o | output | 1 | Pulse: continue at next_pc_o |
| illegal_o | output | 1 | Pulse: illegal-instruction request |
| halt_o | output | 1 | Pulse: halt request |
| stat_we_o | output | 1 | Pulse: write stat_et_o and stat_sup_o into the status register |
| stat_et_o | output | 1 | New trap-enable bit |
| stat_sup_o | output | 1 | New supervisor bit |
| dbg_exit_o | output | 1 | Pulse: leave debug mode |

## Verification
A wrong priority decision shows up one cycle after the strobe. It appears as the wrong pulse, or as a missing or extra status write or debug exit. Stale or corrupted state in the held PC register appears in the first idle cycle that follows, because next_pc_o must not move without a strobe. The bench sweeps all 128 combinations of the seven status and debug inputs, each with several unaligned and wrapping addresses, so every path and every source of restored bits is exercised at the ports.

// File: rtl/rett_pkg.sv
package rett_pkg;

  // Decision taken for one return-from-trap strobe, in priority order.
  typedef enum logic [2:0] {
    PATH_NONE      = 3'd0,
    PATH_USER_HALT = 3'd1,
    PATH_USER_STEP = 3'd2,
    PATH_ILLEGAL   = 3'd3,
    PATH_NORMAL    = 3'd4,
    PATH_DEBUG     = 3'd5,
    PATH_MISMATCH  = 3'd6
  } rett_path_e;

  // Bits restored into the status register on a return path.
  typedef struct packed {
    logic we;
    logic et;
    logic sup;
    logic dbg_exit;
  } rett_stat_upd_t;

endpackage

// File: rtl/rett_prio.sv
module rett_prio
  import rett_pkg::*;
(
  input  logic       valid_i,
  input  logic       sup_i,
  input  logic       trap_en_i,
  input  logic       dbg_state_i,
  input  logic       dbg_field_i,
  output rett_path_e path_o
);

  always_comb begin
    path_o = PATH_NONE;
    if (valid_i) begin
      if (!sup_i) begin
        path_o = trap_en_i ? PATH_USER_STEP : PATH_USER_HALT;
      end else if (trap_en_i) begin
        path_o = PATH_ILLEGAL;
      end else if (!dbg_state_i && !dbg_field_i) begin
        path_o = PATH_NORMAL;
      end else if (dbg_state_i && dbg_field_i) begin
        path_o = PATH_DEBUG;
      end else begin
        path_o = PATH_MISMATCH;
      end
    end
  end

endmodule

// File: rtl/rett_pcsel.sv
module rett_pcsel
  import rett_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int ALIGN_W = 2
) (
  input  rett_path_e        path_i,
  input  logic [PC_W-1:0]   pc_i,
  input  logic [PC_W-1:0]   norm_pc_i,
  input  logic [PC_W-1:0]   dbg_pc_i,
  output logic [PC_W-1:0]   next_pc_o
);

  localparam logic [PC_W-1:0] STEP     = PC_W'(1) << ALIGN_W;
  localparam logic [PC_W-1:0] LOW_MASK = STEP - PC_W'(1);

  logic [PC_W-1:0] pc_al, norm_al, dbg_al, seq_pc;

  generate
    if (ALIGN_W == 0) begin : g_no_align
      assign pc_al   = pc_i;
      assign norm_al = norm_pc_i;
      assign dbg_al  = dbg_pc_i;
    end else begin : g_align
      assign pc_al   = pc_i      & ~LOW_MASK;
      assign norm_al = norm_pc_i & ~LOW_MASK;
      assign dbg_al  = dbg_pc_i  & ~LOW_MASK;
    end
  endgenerate

  assign seq_pc = pc_al + STEP;

  always_comb begin
    unique case (path_i)
      PATH_NORMAL: next_pc_o = norm_al;
      PATH_DEBUG:  next_pc_o = dbg_al;
      default:     next_pc_o = seq_pc;
    endcase
  end

endmodule

// File: rtl/rett_outreg.sv
module rett_outreg
  import rett_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  rett_path_e      path_i,
  input  logic [PC_W-1:0] next_pc_i,
  input  logic            prev_sup_i,
  input  logic            dbg_save_et_i,
  input  logic            dbg_save_sup_i,
  output logic [PC_W-1:0] next_pc_o,
  output logic            redirect_o,
  output logic            illegal_o,
  output logic            halt_o,
  output logic            stat_we_o,
  output logic            stat_et_o,
  output logic            stat_sup_o,
  output logic            dbg_exit_o
);

  rett_stat_upd_t upd;
  logic           take;

  assign take = (path_i != PATH_NONE);

  always_comb begin
    upd = '0;
    unique case (path_i)
      PATH_NORMAL: begin
        upd.we  = 1'b1;
        upd.et  = 1'b1;
        upd.sup = prev_sup_i;
      end
      PATH_DEBUG: begin
        upd.we       = 1'b1;
        upd.et       = dbg_save_et_i;
        upd.sup      = dbg_save_sup_i;
        upd.dbg_exit = 1'b1;
      end
      default: upd = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      next_pc_o  <= '0;
      redirect_o <= 1'b0;
      illegal_o  <= 1'b0;
      halt_o     <= 1'b0;
      stat_we_o  <= 1'b0;
      stat_et_o  <= 1'b0;
      stat_sup_o <= 1'b0;
      dbg_exit_o <= 1'b0;
    end else begin
      if (take) next_pc_o <= next_pc_i;
      halt_o     <= (path_i == PATH_USER_HALT);
      illegal_o  <= (path_i == PATH_ILLEGAL);
      redirect_o <= take && (path_i != PATH_USER_HALT) && (path_i != PATH_ILLEGAL);
      stat_we_o  <= upd.we;
      stat_et_o  <= upd.et;
      stat_sup_o <= upd.sup;
      dbg_exit_o <= upd.dbg_exit;
    end
  end

endmodule

// File: rtl/rett_unit.sv
module rett_unit
  import rett_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int ALIGN_W = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            valid_i,
  input  logic [PC_W-1:0] pc_i,
  input  logic [PC_W-1:0] norm_save_pc_i,
  input  logic [PC_W-1:0] dbg_save_pc_i,
  input  logic            sup_i,
  input  logic            trap_en_i,
  input  logic            prev_sup_i,
  input  logic            dbg_save_et_i,
  input  logic            dbg_save_sup_i,
  input  logic            dbg_state_i,
  input  logic            dbg_field_i,
  output logic [PC_W-1:0] next_pc_o,
  output logic            redirect_o,
  output logic            illegal_o,
  output logic            halt_o,
  output logic            stat_we_o,
  output logic            stat_et_o,
  output logic            stat_sup_o,
  output logic            dbg_exit_o
);

  rett_path_e      path;
  logic [PC_W-1:0] cand_pc;

  rett_prio u_prio (
    .valid_i    (valid_i),
    .sup_i      (sup_i),
    .trap_en_i  (trap_en_i),
    .dbg_state_i(dbg_state_i),
    .dbg_field_i(dbg_field_i),
    .path_o     (path)
  );

  rett_pcsel #(.PC_W(PC_W), .ALIGN_W(ALIGN_W)) u_pcsel (
    .path_i   (path),
    .pc_i     (pc_i),
    .norm_pc_i(norm_save_pc_i),
    .dbg_pc_i (dbg_save_pc_i),
    .next_pc_o(cand_pc)
  );

  rett_outreg #(.PC_W(PC_W)) u_outreg (
    .clk           (clk),
    .rst           (rst),
    .path_i        (path),
    .next_pc_i     (cand_pc),
    .prev_sup_i    (prev_sup_i),
    .dbg_save_et_i (dbg_save_et_i),
    .dbg_save_sup_i(dbg_save_sup_i),
    .next_pc_o     (next_pc_o),
    .redirect_o    (redirect_o),
    .illegal_o     (illegal_o),
    .halt_o        (halt_o),
    .stat_we_o     (stat_we_o),
    .stat_et_o     (stat_et_o),
    .stat_sup_o    (stat_sup_o),
    .dbg_exit_o    (dbg_exit_o)
  );

endmodule

// File: rtl/rett_unit_chk.sv
module rett_unit_chk #(
  parameter int PC_W    = 32,
  parameter int ALIGN_W = 2
) (
  input logic            clk,
  input logic            rst,
  input logic            valid_i,
  input logic            sup_i,
  input logic            trap_en_i,
  input logic            dbg_state_i,
  input logic            dbg_field_i,
  input logic [PC_W-1:0] next_pc_o,
  input logic            redirect_o,
  input logic            illegal_o,
  input logic            halt_o,
  input logic            stat_we_o,
  input logic            stat_et_o,
  input logic            stat_sup_o,
  input logic            dbg_exit_o
);

  localparam logic [PC_W-1:0] LOW_MASK = (PC_W'(1) << ALIGN_W) - PC_W'(1);

  p_single_outcome_r10: assert property (@(posedge clk) disable iff (rst)
    valid_i |=> ($countones({redirect_o, illegal_o, halt_o}) == 1));

  p_quiet_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> !(redirect_o || illegal_o || halt_o || stat_we_o || dbg_exit_o));

  p_pc_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> $stable(next_pc_o));

  p_pc_aligned_r11: assert property (@(posedge clk) disable iff (rst)
    valid_i |=> ((next_pc_o & LOW_MASK) == '0));

  p_halt_cause_r2: assert property (@(posedge clk) disable iff (rst)
    valid_i && !sup_i && !trap_en_i |=> halt_o);

  p_step_cause_r3: assert property (@(posedge clk) disable iff (rst)
    valid_i && !sup_i && trap_en_i |=> redirect_o && !stat_we_o);

  p_illegal_cause_r4: assert property (@(posedge clk) disable iff (rst)
    valid_i && sup_i && trap_en_i |=> illegal_o && !stat_we_o);

  p_normal_ret_r5: assert property (@(posedge clk) disable iff (rst)
    valid_i && sup_i && !trap_en_i && !dbg_state_i && !dbg_field_i
      |=> stat_we_o && stat_et_o && !dbg_exit_o);

  p_debug_ret_r6: assert property (@(posedge clk) disable iff (rst)
    valid_i && sup_i && !trap_en_i && dbg_state_i && dbg_field_i
      |=> stat_we_o && dbg_exit_o && redirect_o);

  p_mismatch_r7: assert property (@(posedge clk) disable iff (rst)
    valid_i && sup_i && !trap_en_i && (dbg_state_i != dbg_field_i)
      |=> redirect_o && !stat_we_o && !dbg_exit_o);

  p_user_first_r8: assert property (@(posedge clk) disable iff (rst)
    valid_i && !sup_i |=> !stat_we_o && !dbg_exit_o);

  p_stat_zero_r12: assert property (@(posedge clk) disable iff (rst)
    !stat_we_o |-> !stat_et_o && !stat_sup_o);

endmodule

bind rett_unit rett_unit_chk #(.PC_W(PC_W), .ALIGN_W(ALIGN_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .valid_i    (valid_i),
  .sup_i      (sup_i),
  .trap_en_i  (trap_en_i),
  .dbg_state_i(dbg_state_i),
  .dbg_field_i(dbg_field_i),
  .next_pc_o  (next_pc_o),
  .redirect_o (redirect_o),
  .illegal_o  (illegal_o),
  .halt_o     (halt_o),
  .stat_we_o  (stat_we_o),
  .stat_et_o  (stat_et_o),
  .stat_sup_o (stat_sup_o),
  .dbg_exit_o (dbg_exit_o)
);

// File: tb/rett_unit_tb_top.sv
`timescale 1ns/1ps
module rett_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst;
  logic        valid_i;
  logic [31:0] pc_i, norm_save_pc_i, dbg_save_pc_i;
  logic        sup_i, trap_en_i, prev_sup_i, dbg_save_et_i, dbg_save_sup_i;
  logic        dbg_state_i, dbg_field_i;
  logic [31:0] next_pc_o;
  logic        redirect_o, illegal_o, halt_o, stat_we_o, stat_et_o, stat_sup_o, dbg_exit_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  rett_unit dut_i (
    .clk(clk), .rst(rst), .valid_i(valid_i), .pc_i(pc_i),
    .norm_save_pc_i(norm_save_pc_i), .dbg_save_pc_i(dbg_save_pc_i),
    .sup_i(sup_i), .trap_en_i(trap_en_i), .prev_sup_i(prev_sup_i),
    .dbg_save_et_i(dbg_save_et_i), .dbg_save_sup_i(dbg_save_sup_i),
    .dbg_state_i(dbg_state_i), .dbg_field_i(dbg_field_i),
    .next_pc_o(next_pc_o), .redirect_o(redirect_o), .illegal_o(illegal_o),
    .halt_o(halt_o), .stat_we_o(stat_we_o), .stat_et_o(stat_et_o),
    .stat_sup_o(stat_sup_o), .dbg_exit_o(dbg_exit_o)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic run_vec(input logic [31:0] pc, input logic [31:0] npc,
                         input logic [31:0] dpc, input logic [6:0] b);
    logic s, et, ps, bet, bs, dst, dfl;
    logic [31:0] e_pc;
    logic e_red, e_ill, e_hlt, e_we, e_et, e_sup, e_exit;
    string tag;
    {s, et, ps, bet, bs, dst, dfl} = b;
    e_pc = (pc & 32'hFFFF_FFFC) + 32'd4;
    e_red = 0; e_ill = 0; e_hlt = 0; e_we = 0; e_et = 0; e_sup = 0; e_exit = 0;
    if (!s) begin
      if (et) begin e_red = 1; tag = "R3"; end
      else begin e_hlt = 1; tag = "R2"; end
    end else if (et) begin
      e_ill = 1; tag = "R4";
    end else if (!dst && !dfl) begin
      e_red = 1; e_we = 1; e_et = 1; e_sup = ps; e_pc = npc & 32'hFFFF_FFFC; tag = "R5";
    end else if (dst && dfl) begin
      e_red = 1; e_we = 1; e_et = bet; e_sup = bs; e_exit = 1;
      e_pc = dpc & 32'hFFFF_FFFC; tag = "R6";
    end else begin
      e_red = 1; tag = "R7";
    end
    // drive on the falling edge, result visible after the next rising edge
    valid_i = 1; pc_i = pc; norm_save_pc_i = npc; dbg_save_pc_i = dpc;
    sup_i = s; trap_en_i = et; prev_sup_i = ps; dbg_save_et_i = bet;
    dbg_save_sup_i = bs; dbg_state_i = dst; dbg_field_i = dfl;
    @(negedge clk);
    valid_i = 0;
    chk(tag, "next_pc", next_pc_o, e_pc);
    chk(tag, "redirect", 32'(redirect_o), 32'(e_red));
    chk(tag, "illegal", 32'(illegal_o), 32'(e_ill));
    chk(tag, "halt", 32'(halt_o), 32'(e_hlt));
    chk(tag, "stat_we", 32'(stat_we_o), 32'(e_we));
    chk(tag, "stat_et", 32'(stat_et_o), 32'(e_et));
    chk(tag, "stat_sup", 32'(stat_sup_o), 32'(e_sup));
    chk(tag, "dbg_exit", 32'(dbg_exit_o), 32'(e_exit));
    chk("R10", "one outcome", 32'(redirect_o + illegal_o + halt_o), 32'd1);
    chk("R11", "low bits", {30'd0, next_pc_o[1:0]}, 32'd0);
    if (!stat_we_o) chk("R12", "stat idle", {30'd0, stat_et_o, stat_sup_o}, 32'd0);
    if (!s) chk("R8", "user first", {30'd0, stat_we_o, dbg_exit_o}, 32'd0);
    // idle cycle: pulses drop, PC holds
    @(negedge clk);
    chk("R9", "idle pulses",
        {27'd0, redirect_o, illegal_o, halt_o, stat_we_o, dbg_exit_o}, 32'd0);
    chk("R9", "pc hold", next_pc_o, e_pc);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    rst = 1; valid_i = 0; pc_i = 32'h1; norm_save_pc_i = 32'h2; dbg_save_pc_i = 32'h3;
    sup_i = 1; trap_en_i = 0; prev_sup_i = 1; dbg_save_et_i = 1; dbg_save_sup_i = 1;
    dbg_state_i = 0; dbg_field_i = 0;
    repeat (3) @(negedge clk);
    chk("R1", "pulses in reset",
        {27'd0, redirect_o, illegal_o, halt_o, stat_we_o, dbg_exit_o}, 32'd0);
    chk("R1", "pc in reset", next_pc_o, 32'd0);
    rst = 0;
    @(negedge clk);
    chk("R1", "after reset",
        {25'd0, redirect_o, illegal_o, halt_o, stat_we_o, stat_et_o, stat_sup_o, dbg_exit_o},
        32'd0);
    chk("R1", "pc after reset", next_pc_o, 32'd0);
    for (int p = 0; p < 3; p++) begin
      logic [31:0] pc, npc, dpc;
      case (p)
        0: begin pc = 32'h0000_1003; npc = 32'h1234_567B; dpc = 32'hA5A5_5A5E; end
        1: begin pc = 32'hFFFF_FFFE; npc = 32'h8000_0001; dpc = 32'h0000_0FFF; end
        default: begin pc = 32'h8000_0000; npc = 32'hFFFF_FFFF; dpc = 32'h7FFF_FFFD; end
      endcase
      for (int b = 0; b < 128; b++) run_vec(pc, npc, dpc, 7'(b));
    end
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule